// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR4 memory interface. It takes the memory device from power-on, or from a warm reset with power held, to the point where training can start. It drives the device reset line, the clock enable, the on-die termination control and a small command bus that carries mode register writes, a long ZQ calibration and deselects. All timing limits arrive as cycle counts on configuration inputs, and the contents of the seven mode registers arrive on one packed input.

After the reset hold, the block releases the device reset. It then waits before raising the clock enable, waits again, and writes the mode registers in a fixed order. The gap after each write depends on what that write changes. Writes that change gear-down, per-device addressing, command/address parity latency, chip-select latency or VrefDQ settings get the longer update wait, and all other writes get the normal gap. Before and after the write that sets the nominal termination, the termination output is held low. A long ZQ calibration follows, and after the calibration wait the block raises `done`. An asynchronous reset starts the cold path. A synchronous `start` pulse starts the warm path at any time, including in the middle of a sequence.

Top module: `ddr4_init_seq`

## Requirements
- R1: From reset entry, `dram_reset_n` and `cke` are both low for exactly max(`t_pw_reset`, `t_cke_lead`, 1) cycles, so the clock enable is low for at least `t_cke_lead` cycles before reset release.
- R2: After `dram_reset_n` rises, `cke` stays low for max(`t_rst_cke`, 1) cycles and then rises and stays high until the next restart.
- R3: The first command is issued exactly max(`t_xpr`, 1) cycles after `cke` rises.
- R4: Exactly eight commands are issued, each lasting one cycle, with deselect (`cmd`=0) in every other cycle. The first seven are mode register writes (`cmd`=1) to MR3, MR6, MR5, MR4, MR2, MR1 and MR0 in that order. Each write carries `bg`={0, n[2]}, `ba`=n[1:0] for register n, and `addr` set to slice n of `mr_data` (bits n*AW up to n*AW+AW-1).
- R5: Two consecutive mode register writes are max(`t_mrd`, 2) cycles apart when the earlier write sets none of its update-wait fields.
- R6: The spacing is max(`t_mrd_ext`, 2) after a write of MR3 with bit 3 or bit 4 set, MR6 with any of bits 7..0 set, MR5 with any of bits 2..0 set, or MR4 with any of bits 8..6 set.
- R7: The eighth command is ZQCL (`cmd`=2, `addr` with only bit 10 set, `bg`=`ba`=0). It is issued max(`t_mod_ext`, 2) cycles after MR0 if MR0 bit 8 (DLL reset) is set, and max(`t_mod`, 2) cycles after MR0 otherwise.
- R8: The write to MR1 follows MR2 by at least `t_odt_lead`+1 cycles, and by the larger of that and the R5/R6 spacing. `odt` is forced low from the cycle after MR2 through `t_mod` cycles after the MR1 write, and equals `odt_req` at all other times.
- R9: `done` rises exactly max(`t_zqinit`, 2) cycles after the ZQCL cycle and stays high, with deselect on the bus, until the next restart.
- R10: A `start` pulse, in any state, shows on the next cycle as `dram_reset_n`, `cke` and `done` all low with deselect on the bus, and the full sequence then repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (cold path) |
| start | input | 1 | Synchronous restart pulse (warm path) |
| t_pw_reset | input | CW | Minimum device reset hold, cycles |
| t_cke_lead | input | CW | Minimum clock-enable low time before reset release, cycles |
| t_rst_cke | input | CW | Reset release to clock-enable rise, cycles |
| t_xpr | input | CW | Clock-enable rise to first command, cycles |
| t_mrd | input | CW | Normal spacing between mode register writes |
| t_mrd_ext | input | CW | Spacing after a write that changes an update-wait field |
| t_mod | input | CW | Mode register write to next non-write command; termination hold after MR1 |
| t_mod_ext | input | CW | Extended wait before ZQCL when MR0 resets the DLL |
| t_odt_lead | input | CW | Cycles with termination forced low before the MR1 write |
| t_zqinit | input | CW | ZQCL to `done` |
| mr_data | input | 7*AW | Mode register contents, register n in slice n |
| odt_req | input | 1 | Termination request passed through outside the forced window |
| dram_reset_n | output | 1 | Device reset, active low |
| cke | output | 1 | Device clock enable |
| odt | output | 1 | Device on-die termination control |
| cmd | output | 2 | 0 deselect, 1 mode register write, 2 ZQCL |
| addr | output | AW | Address field |
| bg | output | 2 | Bank-group field |
| ba | output | 2 | Bank field |
| done | output | 1 | Sequence complete |

## Verification
The embedded properties assume that the timing inputs and `mr_data` do not change while a sequence is running, and that `start` is a pulse rather than a level held high across the checked cycles. The bench changes configuration only just before it asserts reset or pulses `start`. Each restart pulse lasts one cycle, and the bench holds `odt_req` constant for the whole of a run, so any termination mismatch is caused by the forced window. Random configurations clear or keep each update-wait field with equal chance, so both gap rules are exercised after every register.

// File: rtl/ddr4_init_seq.sv
module ddr4_init_seq #(
  parameter int AW = 14,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   t_pw_reset,
  input  logic [CW-1:0]   t_cke_lead,
  input  logic [CW-1:0]   t_rst_cke,
  input  logic [CW-1:0]   t_xpr,
  input  logic [CW-1:0]   t_mrd,
  input  logic [CW-1:0]   t_mrd_ext,
  input  logic [CW-1:0]   t_mod,
  input  logic [CW-1:0]   t_mod_ext,
  input  logic [CW-1:0]   t_odt_lead,
  input  logic [CW-1:0]   t_zqinit,
  input  logic [7*AW-1:0] mr_data,
  input  logic            odt_req,
  output logic            dram_reset_n,
  output logic            cke,
  output logic            odt,
  output logic [1:0]      cmd,
  output logic [AW-1:0]   addr,
  output logic [1:0]      bg,
  output logic [1:0]      ba,
  output logic            done
);

  typedef enum logic [2:0] {S_RST, S_CKEW, S_XPR, S_MRS, S_GAP, S_ZQ, S_ZQW, S_DONE} st_t;

  localparam logic [1:0] C_DES = 2'd0;
  localparam logic [1:0] C_MRS = 2'd1;
  localparam logic [1:0] C_ZQL = 2'd2;

  st_t          state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] odt_cnt;
  logic [2:0]    idx;
  logic [CW:0]   lim;
  logic [CW:0]   sp_base;
  logic [CW:0]   sp;
  logic          ext;

  function automatic logic [2:0] mr_of(input logic [2:0] i);
    case (i)
      3'd0: return 3'd3;
      3'd1: return 3'd6;
      3'd2: return 3'd5;
      3'd3: return 3'd4;
      3'd4: return 3'd2;
      3'd5: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [CW-1:0] dec1(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  wire [2:0]    cur_mr   = mr_of(idx);
  wire [AW-1:0] cur_val  = mr_data[cur_mr*AW +: AW];
  wire          last     = (idx == 3'd6);
  wire          next_mr1 = (mr_of(idx + 3'd1) == 3'd1);
  wire [CW-1:0] rst_len  = (t_pw_reset > t_cke_lead) ? t_pw_reset : t_cke_lead;
  wire [CW:0]   lead_sp  = {1'b0, t_odt_lead} + 1'b1;

  always_comb begin
    case (cur_mr)
      3'd3:    ext = |cur_val[4:3];
      3'd6:    ext = |cur_val[7:0];
      3'd5:    ext = |cur_val[2:0];
      3'd4:    ext = |cur_val[8:6];
      default: ext = 1'b0;
    endcase
    if (last)     sp_base = {1'b0, cur_val[8] ? t_mod_ext : t_mod};
    else          sp_base = {1'b0, ext ? t_mrd_ext : t_mrd};
    sp = (next_mr1 && lead_sp > sp_base) ? lead_sp : sp_base;
  end

  always_comb begin
    case (state)
      S_RST:   lim = {1'b0, dec1(rst_len)};
      S_CKEW:  lim = {1'b0, dec1(t_rst_cke)};
      S_XPR:   lim = {1'b0, dec1(t_xpr)};
      S_GAP:   lim = (sp < 2) ? '0 : sp - 2'd2;
      S_ZQW:   lim = (t_zqinit < 2) ? '0 : {1'b0, t_zqinit} - 2'd2;
      default: lim = '0;
    endcase
  end

  wire hit = ({1'b0, cnt} == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_RST;
      cnt     <= '0;
      idx     <= '0;
      odt_cnt <= '0;
    end else if (start) begin
      state   <= S_RST;
      cnt     <= '0;
      idx     <= '0;
      odt_cnt <= '0;
    end else begin
      if (state == S_MRS && cur_mr == 3'd1) odt_cnt <= t_mod;
      else if (odt_cnt != '0)               odt_cnt <= odt_cnt - 1'b1;
      cnt <= hit ? '0 : cnt + 1'b1;
      if (hit) begin
        case (state)
          S_RST:  state <= S_CKEW;
          S_CKEW: state <= S_XPR;
          S_XPR:  state <= S_MRS;
          S_MRS:  state <= S_GAP;
          S_GAP:  begin
            if (last) state <= S_ZQ;
            else begin
              state <= S_MRS;
              idx   <= idx + 3'd1;
            end
          end
          S_ZQ:   state <= S_ZQW;
          S_ZQW:  state <= S_DONE;
          default: state <= state;
        endcase
      end
    end
  end

  wire odt_force = (state == S_GAP && next_mr1) || (state == S_MRS && cur_mr == 3'd1) || (odt_cnt != '0);

  assign dram_reset_n = (state != S_RST);
  assign cke          = !(state == S_RST || state == S_CKEW);
  assign odt          = odt_req & ~odt_force;
  assign done         = (state == S_DONE);
  assign cmd          = (state == S_MRS) ? C_MRS : (state == S_ZQ) ? C_ZQL : C_DES;

  always_comb begin
    addr = '0;
    bg   = 2'd0;
    ba   = 2'd0;
    if (state == S_MRS) begin
      addr = cur_val;
      bg   = {1'b0, cur_mr[2]};
      ba   = cur_mr[1:0];
    end else if (state == S_ZQ) begin
      addr[10] = 1'b1;
    end
  end

  AST_RST_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_reset_n |-> !cke);                                   // R1
  AST_CKE_LOW_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_reset_n) |-> !cke);                             // R2
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != C_DES |-> cke && dram_reset_n);                     // R4
  AST_CMD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != C_DES && !start |=> cmd == C_DES);                  // R5
  AST_ODT_LOW_MR1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_MRS && ba == 2'd1 && bg == 2'd0 |-> !odt);        // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && cmd == C_DES);                  // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !dram_reset_n && !cke && !done);                 // R10

endmodule

// File: tb/ddr4_init_seq_tb.sv
module ddr4_init_seq_tb;
  localparam int AW = 14;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, start = 0, odt_req = 0;
  logic [CW-1:0] t_pw_reset, t_cke_lead, t_rst_cke, t_xpr, t_mrd, t_mrd_ext;
  logic [CW-1:0] t_mod, t_mod_ext, t_odt_lead, t_zqinit;
  logic [AW-1:0] mr [7];
  logic [7*AW-1:0] mr_data;
  logic dram_reset_n, cke, odt, done;
  logic [1:0] cmd, bg, ba;
  logic [AW-1:0] addr;

  int checks = 0, fails = 0, cyc = 0;
  int t_rel, t_ckeh, t_done, ncmd;
  int cmd_t [8];
  int cmd_c [8], cmd_bg [8], cmd_ba [8], cmd_a [8];
  bit odt_log [8192];

  always_comb for (int k = 0; k < 7; k++) mr_data[k*AW +: AW] = mr[k];

  ddr4_init_seq #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .t_pw_reset(t_pw_reset), .t_cke_lead(t_cke_lead), .t_rst_cke(t_rst_cke), .t_xpr(t_xpr),
    .t_mrd(t_mrd), .t_mrd_ext(t_mrd_ext), .t_mod(t_mod), .t_mod_ext(t_mod_ext),
    .t_odt_lead(t_odt_lead), .t_zqinit(t_zqinit), .mr_data(mr_data), .odt_req(odt_req),
    .dram_reset_n(dram_reset_n), .cke(cke), .odt(odt), .cmd(cmd), .addr(addr),
    .bg(bg), .ba(ba), .done(done));

  always #4 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ord(int i);
    case (i)
      0: return 3; 1: return 6; 2: return 5; 3: return 4;
      4: return 2; 5: return 1; default: return 0;
    endcase
  endfunction

  function automatic bit ext_of(int k, logic [AW-1:0] v);
    case (k)
      3: return |v[4:3];
      6: return |v[7:0];
      5: return |v[2:0];
      4: return |v[8:6];
      default: return 1'b0;
    endcase
  endfunction

  function automatic int spacing(int i);
    int k = ord(i);
    int base;
    if (i == 6) base = mr[0][8] ? int'(t_mod_ext) : int'(t_mod);
    else        base = ext_of(k, mr[k]) ? int'(t_mrd_ext) : int'(t_mrd);
    if (i == 4) base = mx(base, int'(t_odt_lead) + 1);
    return mx(base, 2);
  endfunction

  task automatic monitor(int abort_after);
    t_rel = -1; t_ckeh = -1; t_done = -1; ncmd = 0;
    for (int n = 0; n < 8000; n++) begin
      if (t_rel < 0 && dram_reset_n) t_rel = n;
      if (t_ckeh < 0 && cke) t_ckeh = n;
      odt_log[n] = odt;
      if (cmd != 2'd0) begin
        if (ncmd < 8) begin
          cmd_t[ncmd] = n; cmd_c[ncmd] = cmd; cmd_bg[ncmd] = bg;
          cmd_ba[ncmd] = ba; cmd_a[ncmd] = addr;
        end
        ncmd++;
      end
      if (done) begin t_done = n; break; end
      if (abort_after > 0 && ncmd >= abort_after) break;
      @(negedge clk);
    end
  endtask

  task automatic run(bit cold, bit oreq, int abort_after);
    int em [9];
    string rq;
    odt_req = oreq;
    @(negedge clk);
    if (cold) begin
      rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    end else begin
      start = 1; @(negedge clk); start = 0;
    end
    rq = cold ? "R1" : "R10";
    chk(!dram_reset_n && !cke && !done && cmd == 2'd0, rq, "reset state {rst_n,cke,done,cmd}",
        {dram_reset_n, cke, done, cmd}, 0);
    monitor(abort_after);
    if (abort_after > 0) return;
    em[0] = mx(mx(int'(t_pw_reset), int'(t_cke_lead)), 1);
    em[1] = em[0] + mx(int'(t_rst_cke), 1);
    em[2] = em[1] + mx(int'(t_xpr), 1);
    chk(t_rel == em[0], "R1", "reset release cycle", t_rel, em[0]);
    chk(t_ckeh == em[1], "R2", "cke rise cycle", t_ckeh, em[1]);
    chk(ncmd == 8, "R4", "command count", ncmd, 8);
    for (int j = 0; j < 8 && j < ncmd; j++) begin
      int et = (j == 0) ? em[2] : cmd_t[j-1] + spacing(j - 1);
      if (j == 0) rq = "R3";
      else if (j == 7) rq = "R7";
      else if (j == 5 && int'(t_odt_lead) + 1 > 2) rq = "R8";
      else if (ext_of(ord(j - 1), mr[ord(j - 1)])) rq = "R6";
      else rq = "R5";
      chk(cmd_t[j] == et, rq, $sformatf("command %0d cycle", j), cmd_t[j], et);
      if (j < 7) begin
        int k = ord(j);
        chk(cmd_c[j] == 1 && cmd_bg[j] == (k >> 2) && cmd_ba[j] == (k & 3) && cmd_a[j] == int'(mr[k]),
            "R4", $sformatf("MRS %0d {cmd,bg,ba} / addr", j),
            cmd_c[j]*16 + cmd_bg[j]*4 + cmd_ba[j], 16 + (k >> 2)*4 + (k & 3));
      end else begin
        chk(cmd_c[j] == 2 && cmd_a[j] == 1024 && cmd_bg[j] == 0 && cmd_ba[j] == 0,
            "R7", "ZQCL fields addr", cmd_a[j], 1024);
      end
    end
    if (ncmd == 8) begin
      int bad = 0;
      int ed = cmd_t[7] + mx(int'(t_zqinit), 2);
      for (int n = 0; n <= t_done && n < 8000; n++) begin
        bit forced = (n >= cmd_t[4] + 1) && (n <= cmd_t[5] + int'(t_mod));
        if (odt_log[n] != (oreq && !forced)) bad++;
      end
      chk(bad == 0, "R8", "odt mismatching cycles", bad, 0);
      chk(t_done == ed, "R9", "done cycle", t_done, ed);
    end
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      chk(done && cmd == 2'd0, "R9", "done held with deselect", {done, cmd}, 4);
    end
  endtask

  task automatic set_t(int pw, int lead, int rc, int xpr, int mrd, int mrdx,
                       int md, int mdx, int ol, int zq);
    t_pw_reset = CW'(pw); t_cke_lead = CW'(lead); t_rst_cke = CW'(rc); t_xpr = CW'(xpr);
    t_mrd = CW'(mrd); t_mrd_ext = CW'(mrdx); t_mod = CW'(md); t_mod_ext = CW'(mdx);
    t_odt_lead = CW'(ol); t_zqinit = CW'(zq);
  endtask

  task automatic rand_mr();
    for (int k = 0; k < 7; k++) begin
      mr[k] = AW'($urandom);
      if ($urandom % 2 == 1) begin
        case (k)
          3: mr[k][4:3] = '0;
          6: mr[k][7:0] = '0;
          5: mr[k][2:0] = '0;
          4: mr[k][8:6] = '0;
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_41d4));
    for (int k = 0; k < 7; k++) mr[k] = '0;
    set_t(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 R2 R3: all limits zero take the clamped minimums
    run(1'b1, 1'b1, 0);
    // R5 R6: moderate limits, no update-wait fields set
    set_t(5, 9, 4, 6, 4, 11, 7, 13, 2, 10);
    run(1'b1, 1'b1, 0);
    // R6 R7: every update-wait field set, MR0 requests DLL reset
    mr[3] = 14'h0018; mr[6] = 14'h0080; mr[5] = 14'h0005; mr[4] = 14'h01c0; mr[0] = 14'h0100;
    run(1'b0, 1'b1, 0);
    // R8: termination lead dominates the gap before MR1
    set_t(3, 1, 2, 2, 3, 5, 4, 6, 25, 3);
    run(1'b0, 1'b1, 0);
    // R10: abort mid-sequence, then a full warm run
    set_t(6, 2, 3, 3, 4, 8, 5, 9, 3, 7);
    run(1'b0, 1'b1, 3);
    run(1'b0, 1'b0, 0);
    for (int r = 0; r < 30; r++) begin
      set_t($urandom % 13, $urandom % 13, $urandom % 13, $urandom % 13, $urandom % 13,
            $urandom % 13, $urandom % 13, $urandom % 13, $urandom % 13, $urandom % 13);
      rand_mr();
      if (r % 7 == 3) run(1'b0, 1'b1, 1 + $urandom % 6);
      run(r % 5 == 0, ($urandom % 4) != 0, 0);
    end
    summary();
    $finish;
  end
endmodule